// File: doc/BRIEF.md
# Stored-Program Accumulator Processor

This block is a small multi-cycle processor. Its program and its data sit in one shared memory, which it reaches through a single synchronous port. The block holds a program counter, an instruction register and a small register file. Register 1 plays the accumulator role.

A control sequencer steps through four states: fetch, decode, execute and write-back. Each instruction is one 16-bit word, and an operand field names either a register or a memory word. Three operations are executed:

- a move from memory into a register;
- a move from a register into memory;
- an add of a memory operand onto a register.

A register-to-register move is also accepted. Every other encoding does nothing except advance the program counter.

A halt input parks the sequencer in its fetch state. Debug outputs expose the program counter and the whole register file, so a surrounding test or monitor can follow execution.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, and on the first cycle after it, the program counter reads 0, every register reads 0, no memory write is issued and the memory address equals the program counter.
- R2: An instruction word is laid out as opcode in bits 15:14, destination field in bits 13:7 and source field in bits 6:0. A field with bit 6 set names memory word {0, field[5:0]}. A field with bit 6 clear names register field[5:0], and register 1 is the accumulator.
- R3: Opcode 01 with a register destination and a memory source loads bits 7:0 of the memory word into the register. It takes four clock cycles.
- R4: Opcode 01 with a memory destination and a register source writes the zero-extended register value to that memory word. It raises the write enable for exactly one cycle and takes three cycles.
- R5: Opcode 11 with a register destination and a memory source sets the register to the register plus bits 7:0 of the memory word, modulo 256. It takes four cycles.
- R6: Opcode 01 with register fields on both sides copies the source register into the destination register in three cycles.
- R7: Each of the following takes three cycles and changes no register and no memory word:
  - opcodes 00 and 10;
  - an add whose destination is memory or whose source is a register;
  - a move between two memory words;
  - any register number of 4 or more.
- R8: The program counter rises by one per instruction and wraps from 127 to 0.
- R9: While halt is high in the fetch state, the sequencer stays in fetch, the program counter holds and no memory write occurs.
- R10: The fetch state presents the program counter on the memory address. A register loaded from memory changes only in the fourth cycle of its instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Hold the sequencer in fetch |
| mem_addr | output | 7 | Shared memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| dbg_pc | output | 7 | Current program counter |
| dbg_regs | output | 32 | Register file, register i in bits [8i+7:8i] |

## Verification
The assertions rely on the memory returning read data exactly one cycle after the address it was given. They also rely on halt being changed only while the sequencer is in fetch, which is the only state that samples it.

The bench models the memory as a synchronous array with that one-cycle latency. It keeps the data words well away from the program area, so operand addresses never alias instructions. It raises and drops halt only at instruction boundaries, which it reaches by counting the cycle cost of each instruction.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [1:0] {
      ST_FETCH,
      ST_DECODE,
      ST_EXECUTE,
      ST_WRITEBACK
   } cpu_state_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_LOAD,
      ACT_STORE,
      ACT_ADD,
      ACT_COPY
   } cpu_act_e;

   localparam logic [1:0] OPC_MOVE = 2'b01;
   localparam logic [1:0] OPC_ADD  = 2'b11;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_cpu_pkg::*;
#(
   parameter int OPND_W = 7,
   parameter int NREGS  = 4,
   localparam int INSTR_W = 2 + 2 * OPND_W,
   localparam int RIDX_W  = $clog2(NREGS)
) (
   input  logic [INSTR_W-1:0] ir,
   output cpu_act_e           act,
   output logic [RIDX_W-1:0]  dst_reg,
   output logic [RIDX_W-1:0]  src_reg,
   output logic [OPND_W-2:0]  mem_off
);
   logic [1:0]        opc;
   logic [OPND_W-1:0] dst_f, src_f;
   logic              dst_mem, src_mem, dst_ok, src_ok;

   assign opc   = ir[INSTR_W-1 -: 2];
   assign dst_f = ir[2*OPND_W-1 -: OPND_W];
   assign src_f = ir[OPND_W-1:0];

   assign dst_mem = dst_f[OPND_W-1];
   assign src_mem = src_f[OPND_W-1];
   // a register field is usable only when its number fits the file (R7)
   assign dst_ok  = !dst_mem && (dst_f[OPND_W-2:0] < (OPND_W-1)'(NREGS));
   assign src_ok  = !src_mem && (src_f[OPND_W-2:0] < (OPND_W-1)'(NREGS));

   assign dst_reg = dst_f[RIDX_W-1:0];
   assign src_reg = src_f[RIDX_W-1:0];
   assign mem_off = dst_mem ? dst_f[OPND_W-2:0] : src_f[OPND_W-2:0];

   always_comb begin
      act = ACT_NONE;
      if (opc == OPC_MOVE) begin
         if (dst_ok && src_mem)      act = ACT_LOAD;
         else if (dst_mem && src_ok) act = ACT_STORE;
         else if (dst_ok && src_ok)  act = ACT_COPY;
      end else if (opc == OPC_ADD) begin
         if (dst_ok && src_mem)      act = ACT_ADD;
      end
   end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int DATA_W = 8,
   parameter int NREGS  = 4,
   localparam int RIDX_W = $clog2(NREGS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [RIDX_W-1:0]       widx,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [RIDX_W-1:0]       ridx_a,
   output logic [DATA_W-1:0]       rdata_a,
   input  logic [RIDX_W-1:0]       ridx_b,
   output logic [DATA_W-1:0]       rdata_b,
   output logic [NREGS*DATA_W-1:0] flat
);
   logic [DATA_W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)                                regs[i] <= '0;
         else if (we && widx == RIDX_W'(i))      regs[i] <= wdata;
      end
      assign flat[i*DATA_W +: DATA_W] = regs[i];
   end

   assign rdata_a = regs[ridx_a];
   assign rdata_b = regs[ridx_b];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int PC_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             halt,
   input  cpu_act_e         act,
   output cpu_state_e       state,
   output logic [PC_W-1:0]  pc
);
   cpu_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_FETCH:     if (!halt) nxt = ST_DECODE;
         ST_DECODE:    nxt = ST_EXECUTE;
         ST_EXECUTE:   nxt = (act == ACT_LOAD || act == ACT_ADD) ? ST_WRITEBACK : ST_FETCH;
         ST_WRITEBACK: nxt = ST_FETCH;
         default:      nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         pc    <= '0;
      end else begin
         state <= nxt;
         if (state == ST_DECODE) pc <= pc + PC_W'(1);
      end
   end

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
      state != ST_DECODE |=> pc == $past(pc)); // R8
   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      state == ST_DECODE |=> pc == $past(pc) + PC_W'(1)); // R8
   AST_HALT_PARK: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH && halt) |=> state == ST_FETCH); // R9
   AST_DECODE_NEXT: assert property (@(posedge clk) disable iff (rst)
      state == ST_DECODE |=> state == ST_EXECUTE); // R10
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OPND_W = 7,
   parameter int NREGS  = 4,
   localparam int INSTR_W = 2 + 2 * OPND_W,
   localparam int RIDX_W  = $clog2(NREGS),
   localparam int PC_W    = OPND_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    halt,
   output logic [PC_W-1:0]         mem_addr,
   output logic [INSTR_W-1:0]      mem_wdata,
   output logic                    mem_we,
   input  logic [INSTR_W-1:0]      mem_rdata,
   output logic [PC_W-1:0]         dbg_pc,
   output logic [NREGS*DATA_W-1:0] dbg_regs
);
   if (DATA_W >= INSTR_W) begin : g_bad_width
      $error("data width must be narrower than the instruction word");
   end
   if (NREGS < 2 || (1 << RIDX_W) != NREGS) begin : g_bad_regs
      $error("register count must be a power of two of at least 2");
   end
   if (NREGS > (1 << (OPND_W - 1))) begin : g_bad_field
      $error("register count exceeds the operand field");
   end

   cpu_state_e          state;
   cpu_act_e            act;
   logic [PC_W-1:0]     pc;
   logic [INSTR_W-1:0]  ir;
   logic [RIDX_W-1:0]   dst_reg, src_reg;
   logic [OPND_W-2:0]   mem_off;
   logic [DATA_W-1:0]   rd_a, rd_b, rf_wdata, sum;
   logic                rf_we;

   always_ff @(posedge clk) begin
      if (rst)                    ir <= '0;
      else if (state == ST_DECODE) ir <= mem_rdata;
   end

   acc_decode #(.OPND_W(OPND_W), .NREGS(NREGS)) u_dec (
      .ir(ir), .act(act), .dst_reg(dst_reg), .src_reg(src_reg), .mem_off(mem_off)
   );

   acc_ctrl #(.PC_W(PC_W)) u_ctrl (
      .clk(clk), .rst(rst), .halt(halt), .act(act), .state(state), .pc(pc)
   );

   assign sum = rd_a + mem_rdata[DATA_W-1:0];

   always_comb begin
      rf_we    = 1'b0;
      rf_wdata = rd_b;
      if (state == ST_EXECUTE && act == ACT_COPY) begin
         rf_we = 1'b1;
      end else if (state == ST_WRITEBACK) begin
         rf_we    = 1'b1;
         rf_wdata = (act == ACT_ADD) ? sum : mem_rdata[DATA_W-1:0];
      end
   end

   acc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk(clk), .rst(rst), .we(rf_we), .widx(dst_reg), .wdata(rf_wdata),
      .ridx_a(dst_reg), .rdata_a(rd_a), .ridx_b(src_reg), .rdata_b(rd_b),
      .flat(dbg_regs)
   );

   assign mem_addr  = (state == ST_EXECUTE || state == ST_WRITEBACK) ? {1'b0, mem_off} : pc;
   assign mem_we    = (state == ST_EXECUTE) && (act == ACT_STORE);
   assign mem_wdata = {{(INSTR_W-DATA_W){1'b0}}, rd_b};
   assign dbg_pc    = pc;

   AST_WE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> state == ST_EXECUTE); // R4
   AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we); // R4
   AST_WB_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
      state == ST_WRITEBACK |-> $past(state) == ST_EXECUTE); // R3
   AST_REGS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH || state == ST_DECODE) |=> $stable(dbg_regs)); // R10
   AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH && halt) |-> !mem_we); // R9
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        halt = 1'b0;
   logic [6:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] mem_rdata;
   logic [6:0]  dbg_pc;
   logic [31:0] dbg_regs;

   logic [15:0] mem [128];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   acc_cpu uut (
      .clk(clk), .rst(rst), .halt(halt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
   );

   typedef struct packed {
      logic [15:0] instr;
      logic [2:0]  cyc;
      logic [6:0]  pc;
      logic [31:0] regs;
      logic [6:0]  chk_addr;
      logic [15:0] chk_word;
   } vec_t;

   localparam int NV = 14;
   // regs packed {r3,r2,r1,r0}; memory fields are 7'h40 | address
   localparam vec_t VECS [NV] = '{
      '{ {2'b01,7'h01,7'h68}, 3'd4, 7'd1,  32'h00000500, 7'd44, 16'h0000 }, // R3 R2 load acc
      '{ {2'b11,7'h01,7'h69}, 3'd4, 7'd2,  32'h00000300, 7'd44, 16'h0000 }, // R5 wrap 05+FE
      '{ {2'b01,7'h6C,7'h01}, 3'd3, 7'd3,  32'h00000300, 7'd44, 16'h0003 }, // R4 store
      '{ {2'b01,7'h02,7'h01}, 3'd3, 7'd4,  32'h00030300, 7'd45, 16'h00EE }, // R6 copy
      '{ {2'b11,7'h02,7'h6B}, 3'd4, 7'd5,  32'h003A0300, 7'd45, 16'h00EE }, // R5 upper bits ignored
      '{ {2'b00,7'h01,7'h68}, 3'd3, 7'd6,  32'h003A0300, 7'd45, 16'h00EE }, // R7 opcode 00
      '{ {2'b10,7'h01,7'h6A}, 3'd3, 7'd7,  32'h003A0300, 7'd45, 16'h00EE }, // R7 opcode 10
      '{ {2'b11,7'h6D,7'h01}, 3'd3, 7'd8,  32'h003A0300, 7'd45, 16'h00EE }, // R7 add to memory
      '{ {2'b01,7'h6D,7'h68}, 3'd3, 7'd9,  32'h003A0300, 7'd45, 16'h00EE }, // R7 memory to memory
      '{ {2'b11,7'h01,7'h02}, 3'd3, 7'd10, 32'h003A0300, 7'd45, 16'h00EE }, // R7 add register source
      '{ {2'b01,7'h03,7'h6A}, 3'd4, 7'd11, 32'h103A0300, 7'd45, 16'h00EE }, // R3 load r3
      '{ {2'b01,7'h6E,7'h03}, 3'd3, 7'd12, 32'h103A0300, 7'd46, 16'h0010 }, // R4 store r3
      '{ {2'b01,7'h00,7'h6B}, 3'd4, 7'd13, 32'h103A0337, 7'd46, 16'h0010 }, // R3 load r0
      '{ {2'b01,7'h05,7'h68}, 3'd3, 7'd14, 32'h103A0337, 7'd45, 16'h00EE }  // R7 register 5 absent
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
      for (int i = 0; i < NV; i++) mem[i] = VECS[i].instr;
      mem[NV] = {2'b01, 7'h01, 7'h6A};   // load acc from word 42 for the timing test
      mem[40] = 16'h0005;
      mem[41] = 16'h00FE;
      mem[42] = 16'h0010;
      mem[43] = 16'hAB37;
      mem[45] = 16'h00EE;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset pc", 32'(dbg_pc), 32'd0);
      check("R1 reset regs", dbg_regs, 32'h0);
      check("R1 reset we", 32'(mem_we), 32'd0);
      rst = 1'b0;
      check("R1 addr equals pc", 32'(mem_addr), 32'd0);

      for (int i = 0; i < NV; i++) begin
         repeat (int'(VECS[i].cyc)) @(posedge clk);
         @(negedge clk);
         check($sformatf("R8 vec%0d pc", i), 32'(dbg_pc), 32'(VECS[i].pc));
         check($sformatf("R2 vec%0d regs", i), dbg_regs, VECS[i].regs);
         check($sformatf("R4 vec%0d mem", i), 32'(mem[VECS[i].chk_addr]), 32'(VECS[i].chk_word));
      end

      // R9: halt parks in fetch
      halt = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R9 halt pc", 32'(dbg_pc), 32'd14);
      check("R9 halt regs", dbg_regs, 32'h103A0337);
      check("R9 halt we", 32'(mem_we), 32'd0);
      check("R10 fetch addr", 32'(mem_addr), 32'd14);
      halt = 1'b0;

      // R10: load lands in the fourth cycle only
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 pc before wb", 32'(dbg_pc), 32'd15);
      check("R10 acc before wb", dbg_regs, 32'h103A0337);
      @(posedge clk);
      @(negedge clk);
      check("R3 acc after wb", dbg_regs, 32'h103A1037);

      // R8: 113 three-cycle no-ops bring the pc round to 0
      repeat (339) @(posedge clk);
      @(negedge clk);
      check("R8 pc wrap", 32'(dbg_pc), 32'd0);
      check("R7 zero words leave regs", dbg_regs, 32'h103A1037);

      // R1: reset in mid-run
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 rerun pc", 32'(dbg_pc), 32'd0);
      check("R1 rerun regs", dbg_regs, 32'h0);
      check("R1 rerun we", 32'(mem_we), 32'd0);
      report();
   end
endmodule